// File: doc/BRIEF.md
# Programmable Loss-of-Signal Detector

This block watches a receive line one pulse period at a time and declares Loss of Signal (LOS) once the line has carried no pulse for a programmable number of consecutive periods. Each period arrives as one sample on a valid-qualified input. The sample carries two views of the line. One is the raw digital data bit. The other is the output of an external amplitude comparator, used in analog mode. A mode pin picks which view counts as "pulse present". The block always accepts a sample: there is no back-pressure and no ready signal, and a cycle without `smp_valid` is simply not a pulse period.

The silence threshold comes from an 8-bit configuration value scaled by 16 periods. A value of zero selects the shortest window of 16 periods. LOS drops as soon as a pulse is seen, and the silence count starts again from zero.

A sticky interrupt flag records LOS events. It can record the onset of LOS only, or every change of the LOS status in either direction. A mask stops new events from being recorded. Pulsing `irq_clr` for one cycle clears the flag.

Top module: `los_detector`

## Requirements
- R1: After reset `los` and `irq` are both 0.
- R2: Let N = `thresh`×16, with `thresh`=0 giving N=16. `los` goes to 1 on the clock edge that accepts the N-th consecutive valid no-pulse sample. It is visible in the following cycle and is not set by N−1 samples.
- R3: With `mode_analog`=0, `smp_data`=0 means no pulse and `smp_data`=1 means pulse, and `smp_cmp` has no effect.
- R4: With `mode_analog`=1, `smp_cmp`=0 means no pulse and `smp_cmp`=1 means pulse, and `smp_data` has no effect.
- R5: A valid pulse sample clears `los` at that edge and restarts the silence count, so a fresh N no-pulse samples are needed to raise `los` again.
- R6: Cycles with `smp_valid`=0 change neither `los` nor the silence count.
- R7: With `irq_any_change`=0, the flag `irq` is set at the edge where `los` rises. A falling `los` does not set it.
- R8: With `irq_any_change`=1, the flag `irq` is set at both rising and falling edges of `los`.
- R9: While `irq_mask`=1, LOS events do not set `irq`, and a flag that is already set stays set.
- R10: `irq_clr`=1 clears `irq` at the next edge. If an unmasked event happens in the same cycle, the set wins and `irq` stays 1.
- R11: The silence count saturates and does not wrap. `los` stays 1 through arbitrarily long silences, including runs past 4096 periods at every threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One pulse period is presented this cycle |
| smp_data | input | 1 | Digital line bit, 1 = pulse |
| smp_cmp | input | 1 | Analog comparator result, 1 = pulse above level |
| mode_analog | input | 1 | 0 = digital source, 1 = comparator source |
| thresh | input | 8 | Silence window in units of 16 periods (0 means 16) |
| irq_any_change | input | 1 | 1 = interrupt on every LOS change, 0 = onset only |
| irq_mask | input | 1 | 1 = do not record new LOS events |
| irq_clr | input | 1 | Clear the sticky interrupt flag |
| los | output | 1 | Loss-of-signal status |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps thresholds 0 through 15 and 255. At each one it checks the exact boundary between N−1 and N silent periods. An off-by-one in the limit, or in the zero-means-16 rule, fires a period early or late. Idle gaps are placed just short of the threshold, so a design that counts idle cycles or loses count across them declares LOS at the wrong period. Silences of 5000 periods expose a counter that wraps and drops LOS. The interrupt tests cover a fall in onset-only mode, masking with a flag already set, and a clear in the same cycle as an event, where a design with the wrong priority loses the interrupt.

// File: rtl/los_det_pkg.sv
package los_det_pkg;

  typedef enum logic {
    SRC_DIGITAL = 1'b0,
    SRC_ANALOG  = 1'b1
  } los_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } los_edge_t;

endpackage

// File: rtl/los_sample_sel.sv
module los_sample_sel
  import los_det_pkg::*;
(
  input  logic     smp_data,
  input  logic     smp_cmp,
  input  los_src_e src,
  output logic     pulse
);

  always_comb begin
    unique case (src)
      SRC_ANALOG:  pulse = smp_cmp;
      default:     pulse = smp_data;
    endcase
  end

endmodule

// File: rtl/los_run_counter.sv
module los_run_counter #(
  parameter int TH_W     = 8,
  parameter int SCALE_LG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            pulse,
  input  logic [TH_W-1:0] thresh,
  output logic            los_now,
  output logic            los_nx
);

  localparam int CNT_W = TH_W + SCALE_LG;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(1) << SCALE_LG;

  logic [CNT_W-1:0] run_q, run_nx, limit;

  always_comb begin
    if (thresh == '0) limit = MIN_LIM;
    else              limit = {thresh, {SCALE_LG{1'b0}}};
  end

  always_comb begin
    run_nx = run_q;
    los_nx = los_now;
    if (valid) begin
      if (pulse) begin
        run_nx = '0;
        los_nx = 1'b0;
      end else begin
        run_nx = (run_q == CNT_MAX) ? run_q : run_q + CNT_W'(1);
        los_nx = (run_nx >= limit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      los_now <= 1'b0;
    end else begin
      run_q   <= run_nx;
      los_now <= los_nx;
    end
  end

endmodule

// File: rtl/los_irq_ctrl.sv
module los_irq_ctrl
  import los_det_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic los_now,
  input  logic los_nx,
  input  logic any_change,
  input  logic mask,
  input  logic clr,
  output logic flag
);

  los_edge_t edg;
  logic      ev, set;

  always_comb begin
    edg.rise = los_nx & ~los_now;
    edg.fall = ~los_nx & los_now;
    ev       = edg.rise | (any_change & edg.fall);
    set      = ev & ~mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_det_pkg::*;
#(
  parameter int TH_W     = 8,
  parameter int SCALE_LG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic            smp_data,
  input  logic            smp_cmp,
  input  logic            mode_analog,
  input  logic [TH_W-1:0] thresh,
  input  logic            irq_any_change,
  input  logic            irq_mask,
  input  logic            irq_clr,
  output logic            los,
  output logic            irq
);

  los_src_e src;
  logic     pulse, los_nx;

  assign src = los_src_e'(mode_analog);

  los_sample_sel u_sel (
    .smp_data (smp_data),
    .smp_cmp  (smp_cmp),
    .src      (src),
    .pulse    (pulse)
  );

  los_run_counter #(.TH_W(TH_W), .SCALE_LG(SCALE_LG)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (smp_valid),
    .pulse   (pulse),
    .thresh  (thresh),
    .los_now (los),
    .los_nx  (los_nx)
  );

  los_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .los_now    (los),
    .los_nx     (los_nx),
    .any_change (irq_any_change),
    .mask       (irq_mask),
    .clr        (irq_clr),
    .flag       (irq)
  );

endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_data,
  input logic smp_cmp,
  input logic mode_analog,
  input logic irq_any_change,
  input logic irq_mask,
  input logic irq_clr,
  input logic los,
  input logic irq
);

  logic seen_pulse;
  assign seen_pulse = mode_analog ? smp_cmp : smp_data;

  // R5
  pulse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && seen_pulse) |=> !los);

  // R2
  rise_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(smp_valid && !seen_pulse));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(los));

  // R7
  rise_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) && $past(!irq_mask)) |-> irq);

  // R7
  fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(los) && $past(!irq_any_change) && $past(!irq)) |-> !irq);

  // R9
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask && !irq) |=> !irq);

  // R10
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

endmodule

bind los_detector los_detector_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .smp_valid      (smp_valid),
  .smp_data       (smp_data),
  .smp_cmp        (smp_cmp),
  .mode_analog    (mode_analog),
  .irq_any_change (irq_any_change),
  .irq_mask       (irq_mask),
  .irq_clr        (irq_clr),
  .los            (los),
  .irq            (irq)
);

// File: tb/los_detector_test.sv
module los_detector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_data = 1'b0, smp_cmp = 1'b0;
  logic       mode_analog = 1'b0;
  logic [7:0] thresh = 8'd0;
  logic       irq_any_change = 1'b0, irq_mask = 1'b0, irq_clr = 1'b0;
  logic       los, irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  los_detector uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_cmp(smp_cmp), .mode_analog(mode_analog), .thresh(thresh),
    .irq_any_change(irq_any_change), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .los(los), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the edge that captured it
  task automatic step(input logic v, input logic d, input logic c, input logic clr);
    @(negedge clk);
    smp_valid = v; smp_data = d; smp_cmp = c; irq_clr = clr;
    @(posedge clk);
    #1;
    smp_valid = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic int limit_of(input int t);
    return (t == 0) ? 16 : t * 16;
  endfunction

  task automatic sweep_one(input int t);
    int n;
    n = limit_of(t);
    thresh = 8'(t);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    zeros(n - 1);
    chk(los, 1'b0, $sformatf("R2 t=%0d before limit", t));
    zeros(1);
    chk(los, 1'b1, $sformatf("R2 t=%0d at limit", t));
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    chk(los, 1'b1, $sformatf("R6 t=%0d idle keeps los", t));
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(los, 1'b0, $sformatf("R5 t=%0d pulse clears", t));
    zeros(n - 1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    chk(los, 1'b0, $sformatf("R6 t=%0d idle adds nothing", t));
    zeros(1);
    chk(los, 1'b1, $sformatf("R6 t=%0d count held over idle", t));
    step(1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    irq_mask = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(los, 1'b0, "R1 los reset");
    chk(irq, 1'b0, "R1 irq reset");
    @(negedge clk);
    rst_n = 1'b1;

    // threshold sweep, digital source
    for (int t = 0; t < 16; t++) sweep_one(t);
    sweep_one(255);

    // R3: comparator ignored in digital mode
    mode_analog = 1'b0;
    thresh = 8'd1;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(los, 1'b1, "R3 data zero with cmp high");
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(los, 1'b0, "R3 data one with cmp low");

    // R4: data ignored in analog mode
    mode_analog = 1'b1;
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(los, 1'b0, "R4 15 silent periods");
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(los, 1'b1, "R4 cmp low with data high");
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(los, 1'b0, "R4 cmp high clears");
    mode_analog = 1'b0;

    // R11: saturation at short and long thresholds
    thresh = 8'd0;
    zeros(5000);
    chk(los, 1'b1, "R11 t=0 long silence");
    step(1'b1, 1'b1, 1'b0, 1'b0);
    thresh = 8'd255;
    zeros(5000);
    chk(los, 1'b1, "R11 t=255 long silence");
    step(1'b1, 1'b1, 1'b0, 1'b0);

    // interrupts, thresh 0 => 16 periods
    thresh = 8'd0;
    irq_mask = 1'b0;
    irq_any_change = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(irq, 1'b0, "R10 flag clear at start");
    zeros(16);
    chk(irq, 1'b1, "R7 rise sets flag");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(irq, 1'b0, "R10 clear works");
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(irq, 1'b0, "R7 fall ignored in onset mode");

    irq_any_change = 1'b1;
    zeros(16);
    chk(irq, 1'b1, "R8 rise sets flag");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(irq, 1'b1, "R8 fall sets flag");

    irq_mask = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk(irq, 1'b1, "R9 set flag kept under mask");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    zeros(16);
    chk(los, 1'b1, "R9 los still reported");
    chk(irq, 1'b0, "R9 masked rise not recorded");
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk(irq, 1'b0, "R9 masked fall not recorded");

    irq_mask = 1'b0;
    irq_any_change = 1'b0;
    zeros(15);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    chk(irq, 1'b1, "R10 set wins over clear");
    chk(los, 1'b1, "R2 los with simultaneous clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule